// File: doc/BRIEF.md
# Polynomial-Differenced Alias-Suppressed Oscillator

This block generates band-limited-ish audio waveforms without a wavetable. An unsigned phase accumulator advances by a programmable increment once per produced sample; its top bits, read as a signed fraction in [-1, 1), form a naive sawtooth. That sawtooth is pushed through the even quartic x⁴ − 2x², and three first differences of the result recover a sawtooth whose discontinuity has been smoothed, which pushes most aliasing down. A second phase, offset from the first, runs through the same polynomial. Subtracting the two yields a pulse whose width follows the offset. Stopping after two differences yields a triangle.

The difference chain is kept far wider than the output word, so very low notes keep their precision. The result is then multiplied by a per-note gain supplied from outside and cut down to the output width. The gain is roughly P³/192 for sawtooth and pulse, where P is the period in samples, and it tracks P²/96 for the triangle. An optional averaging mode makes the last difference span two samples and halves it, which damps content near the Nyquist frequency.

Samples leave on a valid/ready stream. A sample is computed when `step_en` is high and the output slot is free, meaning `out_valid` is low or `out_ready` is high. While the consumer stalls, the held sample stays unchanged, and a `step_en` pulse during the stall is dropped: the phase does not move and no history shifts.

Top module: `dpw_osc`

## Requirements
- R1: While and right after `rst` is high, `out_valid` is 0 and `out_data` is 0.
- R2: Each produced sample advances the phase by `phase_inc` modulo 2^PHASE_W. The naive value is the top SAW_W phase bits read as two's complement with SAW_W−1 fraction bits.
- R3: The naive value x is mapped to x⁴ − 2x², held exactly with 4·(SAW_W−1) fraction bits.
- R4: With `wave_sel`=0, the output is the third difference p[n]−3p[n−1]+3p[n−2]−p[n−3] of the polynomial. It is multiplied by unsigned `scale`, which has SCALE_FRAC fraction bits, then arithmetically shifted right by 4·(SAW_W−1)+SCALE_FRAC−(OUT_W−1), and the low OUT_W bits are kept.
- R5: With `wave_sel`=1 (pulse), the polynomial source is poly(phase) − poly(phase+`pulse_offset`), differenced three times and scaled as in R4.
- R6: With `wave_sel`=2 (triangle), the pulse source is differenced only twice, then scaled as in R4.
- R7: With `avg_en`=1, the last difference of the chosen path is replaced by (v[n] − v[n−2]) shifted right arithmetically by one.
- R8: `wave_sel`=3 behaves as sawtooth. It is still a distinct code, so switching between 0 and 3 restarts the warm-up.
- R9: The first 3 samples after reset are 0. With `avg_en`=1 the first 4 are 0. The same applies after any change of `wave_sel`, and the sample on which the change is seen counts as the first of them.
- R10: `out_valid` rises with each produced sample. While `out_valid`=1 and `out_ready`=0, `out_data` and `out_valid` hold.
- R11: A `step_en` pulse while the output slot is occupied is ignored. The sample stream afterwards continues as if the pulse had never occurred.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| step_en | input | 1 | Request for one new sample |
| phase_inc | input | PHASE_W | Phase step per sample |
| pulse_offset | input | PHASE_W | Phase offset of the second generator, sets the pulse width |
| wave_sel | input | 2 | 0 saw, 1 pulse, 2 triangle, 3 saw (alternate code) |
| scale | input | SCALE_W | Unsigned per-note gain, SCALE_FRAC fraction bits |
| avg_en | input | 1 | Use the averaged last difference |
| out_ready | input | 1 | Consumer accepts the sample |
| out_valid | output | 1 | Sample available |
| out_data | output | OUT_W | Sample, two's complement, OUT_W−1 fraction bits |

## Verification
The scoreboard exercises the warm-up window after reset, after a select change and in averaged mode. A design that miscounted it would leak a large transient spike or swallow the first good sample. Runs span more than one period, so a wrong wrap or a wrong sign on the naive value corrupts the samples around the discontinuity. The pulse width is changed mid-run and the triangle is tapped with and without averaging, which exposes a wrong tap or a history that skips a stage. A stalled output is held while an extra strobe arrives. A design that let that strobe advance the phase would shift every later sample by one step.

// File: rtl/dpw_osc_pkg.sv
package dpw_osc_pkg;

  typedef enum logic [1:0] {
    WAVE_SAW     = 2'd0,
    WAVE_PULSE   = 2'd1,
    WAVE_TRI     = 2'd2,
    WAVE_SAW_ALT = 2'd3
  } wave_e;

  // pulse and triangle both subtract the offset generator's polynomial
  function automatic logic wave_uses_pair(wave_e w);
    return (w == WAVE_PULSE) || (w == WAVE_TRI);
  endfunction

  // triangle stops one difference early
  function automatic logic wave_taps_second(wave_e w);
    return w == WAVE_TRI;
  endfunction

endpackage

// File: rtl/dpw_poly.sv
module dpw_poly #(
  parameter int SAW_W = 12
) (
  input  logic [SAW_W-1:0]          saw_bits,
  output logic signed [4*SAW_W-1:0] poly
);
  localparam int FRAC = SAW_W - 1;
  localparam int SQW  = 2 * SAW_W;
  localparam int QW   = 4 * SAW_W;

  logic signed [SAW_W-1:0] x;
  logic signed [SQW-1:0]   sq;
  logic signed [QW-1:0]    quad;
  logic signed [QW-1:0]    twice_sq;

  assign x        = $signed(saw_bits);
  assign sq       = x * x;                            // one multiply
  assign quad     = QW'(sq) * QW'(sq);                // x^4 from the square
  assign twice_sq = QW'(sq) <<< (2 * FRAC + 1);       // 2*x^2 by shift, aligned to 4*FRAC
  assign poly     = quad - twice_sq;
endmodule

// File: rtl/dpw_diff_stage.sv
module dpw_diff_stage #(
  parameter int W = 52
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                adv,
  input  logic signed [W-1:0] din,
  output logic signed [W-1:0] d_plain,
  output logic signed [W-1:0] d_avg
);
  logic signed [W-1:0] prev1_q, prev2_q;

  assign d_plain = din - prev1_q;
  assign d_avg   = (din - prev2_q) >>> 1;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev1_q <= '0;
      prev2_q <= '0;
    end else if (adv) begin
      prev1_q <= din;
      prev2_q <= prev1_q;
    end
  end

  // R7: two-deep history shifts only on a produced sample
  p_hist_shift_r7: assert property (@(posedge clk) disable iff (rst)
    adv |=> (prev2_q == $past(prev1_q)) && (prev1_q == $past(din)));
  p_hist_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(prev1_q) && $stable(prev2_q));
endmodule

// File: rtl/dpw_scaler.sv
module dpw_scaler #(
  parameter int DW      = 52,
  parameter int SCALE_W = 32,
  parameter int OUT_W   = 16,
  parameter int SHIFT   = 45
) (
  input  logic signed [DW-1:0] val,
  input  logic [SCALE_W-1:0]   scale,
  output logic [OUT_W-1:0]     res
);
  localparam int PRODW = DW + SCALE_W + 1;

  logic signed [PRODW-1:0] prod;
  logic unused_prod_bits;

  assign prod = PRODW'(val) * $signed({1'b0, scale});
  assign res  = prod[SHIFT +: OUT_W];
  assign unused_prod_bits = ^{prod[PRODW-1:SHIFT+OUT_W], prod[SHIFT-1:0]};

  initial begin
    p_shift_fits_r4: assert (SHIFT > 0 && SHIFT + OUT_W <= PRODW);
  end
endmodule

// File: rtl/dpw_osc.sv
module dpw_osc
  import dpw_osc_pkg::*;
#(
  parameter int PHASE_W    = 24,
  parameter int SAW_W      = 12,
  parameter int OUT_W      = 16,
  parameter int SCALE_W    = 32,
  parameter int SCALE_FRAC = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               step_en,
  input  logic [PHASE_W-1:0] phase_inc,
  input  logic [PHASE_W-1:0] pulse_offset,
  input  logic [1:0]         wave_sel,
  input  logic [SCALE_W-1:0] scale,
  input  logic               avg_en,
  input  logic               out_ready,
  output logic               out_valid,
  output logic [OUT_W-1:0]   out_data
);
  localparam int FRAC       = SAW_W - 1;
  localparam int POLY_W     = 4 * SAW_W;
  localparam int DW         = POLY_W + 4;   // source subtraction plus three differences
  localparam int SHIFT      = 4 * FRAC + SCALE_FRAC - (OUT_W - 1);
  localparam int N_STG      = 3;
  localparam int N_GEN      = 2;
  localparam int FILL_W     = 3;
  localparam logic [FILL_W-1:0] FILL_PLAIN = FILL_W'(3);
  localparam logic [FILL_W-1:0] FILL_AVG   = FILL_W'(4);

  logic [PHASE_W-1:0]       phase_q;
  logic [1:0]               wave_q;
  logic [FILL_W-1:0]        fill_q;
  logic                     advance;
  wave_e                    sel_w;

  logic [PHASE_W-1:0]       ph_gen [N_GEN];
  logic signed [POLY_W-1:0] poly_v [N_GEN];
  logic signed [DW-1:0]     src;
  logic signed [DW-1:0]     st_in  [N_STG];
  logic signed [DW-1:0]     st_pl  [N_STG];
  logic signed [DW-1:0]     st_av  [N_STG];
  logic signed [DW-1:0]     tap;
  logic [OUT_W-1:0]         scaled;
  logic                     sel_change;
  logic [FILL_W-1:0]        fill_thr;
  logic                     warm;
  logic                     unused_stage_bits;

  assign advance = step_en && (!out_valid || out_ready);
  assign sel_w   = wave_e'(wave_sel);

  // two phase generators: main and offset copy
  assign ph_gen[0] = phase_q;
  assign ph_gen[1] = phase_q + pulse_offset;

  for (genvar g = 0; g < N_GEN; g++) begin : g_gen
    dpw_poly #(.SAW_W(SAW_W)) u_poly (
      .saw_bits (ph_gen[g][PHASE_W-1 -: SAW_W]),
      .poly     (poly_v[g])
    );
  end

  always_comb begin
    if (wave_uses_pair(sel_w)) src = DW'(poly_v[0]) - DW'(poly_v[1]);
    else                       src = DW'(poly_v[0]);
  end

  for (genvar s = 0; s < N_STG; s++) begin : g_stg
    if (s == 0) begin : g_first
      assign st_in[s] = src;
    end else begin : g_next
      assign st_in[s] = st_pl[s-1];
    end
    dpw_diff_stage #(.W(DW)) u_stage (
      .clk     (clk),
      .rst     (rst),
      .adv     (advance),
      .din     (st_in[s]),
      .d_plain (st_pl[s]),
      .d_avg   (st_av[s])
    );
  end

  assign unused_stage_bits = ^{st_av[0], ph_gen[0][PHASE_W-SAW_W-1:0], ph_gen[1][PHASE_W-SAW_W-1:0]};

  always_comb begin
    if (wave_taps_second(sel_w)) tap = avg_en ? st_av[1] : st_pl[1];
    else                         tap = avg_en ? st_av[2] : st_pl[2];
  end

  dpw_scaler #(
    .DW(DW), .SCALE_W(SCALE_W), .OUT_W(OUT_W), .SHIFT(SHIFT)
  ) u_scaler (
    .val   (tap),
    .scale (scale),
    .res   (scaled)
  );

  assign sel_change = (wave_sel != wave_q);
  assign fill_thr   = avg_en ? FILL_AVG : FILL_PLAIN;
  assign warm       = sel_change || (fill_q < fill_thr);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q   <= '0;
      wave_q    <= 2'd0;
      fill_q    <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      if (advance) begin
        phase_q   <= phase_q + phase_inc;
        wave_q    <= wave_sel;
        if (sel_change)              fill_q <= FILL_W'(1);
        else if (fill_q < fill_thr)  fill_q <= fill_q + FILL_W'(1);
        out_data  <= warm ? '0 : scaled;
        out_valid <= 1'b1;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  // R2: phase moves by exactly one increment per produced sample
  p_phase_step_r2: assert property (@(posedge clk) disable iff (rst)
    advance |=> phase_q == PHASE_W'($past(phase_q) + $past(phase_inc)));
  // R11: no produced sample, no phase movement
  p_phase_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !advance |=> $stable(phase_q));
  // R10: stalled sample is held
  p_stall_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> out_valid && $stable(out_data));
  // R10: a produced sample is always presented
  p_valid_rise_r10: assert property (@(posedge clk) disable iff (rst)
    advance |=> out_valid);
  // R9: a select change mutes the sample on which it is seen
  p_change_mutes_r9: assert property (@(posedge clk) disable iff (rst)
    (advance && (wave_sel != wave_q)) |=> out_data == '0);
  // R9: warm-up counter never passes the averaged depth
  p_fill_bound_r9: assert property (@(posedge clk) disable iff (rst)
    fill_q <= FILL_AVG);
endmodule

// File: tb/dpw_osc_bench.sv
module dpw_osc_bench;
  localparam int PW  = 24;
  localparam int SW  = 12;
  localparam int OW  = 16;
  localparam int SCW = 32;
  localparam int SCF = 16;
  localparam int F   = SW - 1;
  localparam int SH  = 4 * F + SCF - (OW - 1);

  typedef logic signed [127:0] wide_t;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          step_en = 1'b0;
  logic [PW-1:0] phase_inc = '0;
  logic [PW-1:0] pulse_offset = '0;
  logic [1:0]    wave_sel = 2'd0;
  logic [SCW-1:0] scale = '0;
  logic          avg_en = 1'b0;
  logic          out_ready = 1'b1;
  logic          out_valid;
  logic [OW-1:0] out_data;

  always #5 clk = ~clk;

  dpw_osc #(.PHASE_W(PW), .SAW_W(SW), .OUT_W(OW), .SCALE_W(SCW), .SCALE_FRAC(SCF)) u_dpw_osc (
    .clk(clk), .rst(rst), .step_en(step_en), .phase_inc(phase_inc),
    .pulse_offset(pulse_offset), .wave_sel(wave_sel), .scale(scale),
    .avg_en(avg_en), .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data)
  );

  int n_vec = 0;
  int n_bad = 0;
  logic [OW-1:0] exp_q [$];
  string         tag_q [$];

  // reference model state
  logic [PW-1:0] m_ph;
  wide_t         mp [5];
  int            m_fill;
  logic [1:0]    m_wq;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic wide_t polyf(input logic [PW-1:0] ph);
    wide_t x;
    x = $signed(ph[PW-1 -: SW]);
    return x * x * x * x - ((x * x) <<< (2 * F + 1));
  endfunction

  function automatic void model_reset();
    m_ph = '0; m_fill = 0; m_wq = 2'd0;
    for (int i = 0; i < 5; i++) mp[i] = '0;
  endfunction

  function automatic logic [OW-1:0] model_step(output bit muted);
    wide_t pn, v, prod, sc, res;
    logic [PW-1:0] pb;
    int thr;
    bit pair, tri_w;
    pair  = (wave_sel == 2'd1) || (wave_sel == 2'd2);
    tri_w = (wave_sel == 2'd2);
    pb = m_ph + pulse_offset;
    pn = polyf(m_ph);
    if (pair) pn = pn - polyf(pb);
    for (int i = 4; i > 0; i--) mp[i] = mp[i-1];
    mp[0] = pn;
    thr = avg_en ? 4 : 3;
    muted = 1'b0;
    if (wave_sel != m_wq) begin
      m_wq = wave_sel; m_fill = 1; muted = 1'b1;
    end else if (m_fill < thr) begin
      m_fill++; muted = 1'b1;
    end
    if (tri_w) v = avg_en ? (mp[0] - mp[1] - mp[2] + mp[3]) >>> 1
                          : mp[0] - 2 * mp[1] + mp[2];
    else       v = avg_en ? (mp[0] - 2 * mp[1] + 2 * mp[3] - mp[4]) >>> 1
                          : mp[0] - 3 * mp[1] + 3 * mp[2] - mp[3];
    sc   = {96'd0, scale};
    prod = v * sc;
    res  = prod >>> SH;
    m_ph = m_ph + phase_inc;
    return muted ? '0 : res[OW-1:0];
  endfunction

  // driver: one sample request, expected value pushed to the scoreboard
  task automatic step(input string tag);
    bit muted;
    logic [OW-1:0] e;
    while (out_valid && !out_ready) @(negedge clk);
    step_en = 1'b1;
    e = model_step(muted);
    exp_q.push_back(e);
    tag_q.push_back(muted ? "R9" : tag);
    @(negedge clk);
    step_en = 1'b0;
  endtask

  task automatic run(input int n, input string tag);
    for (int i = 0; i < n; i++) step(tag);
  endtask

  task automatic drain();
    while (exp_q.size() != 0 || out_valid) @(negedge clk);
  endtask

  task automatic do_reset();
    drain();
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(!out_valid && out_data == '0, "R1", longint'(out_data), 0);
    model_reset();
    rst = 1'b0;
  endtask

  // monitor: compare each accepted sample against the scoreboard
  always @(negedge clk) begin
    if (!rst && out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R10", longint'(out_data), -1);
      end else begin
        logic [OW-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(out_data == e, t, longint'($signed(out_data)), longint'($signed(e)));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [OW-1:0] held;
    model_reset();
    repeat (3) @(negedge clk);
    check(!out_valid && out_data == '0, "R1", longint'(out_data), 0);
    rst = 1'b0;

    // R4 / R2: sawtooth, 64-sample period, over two wraps
    phase_inc = 24'd262144; scale = 32'd89587712; wave_sel = 2'd0;
    run(64, "R4");
    run(80, "R2");

    // R3: faster saw, different polynomial region density
    phase_inc = 24'd524288; scale = 32'd11184810;
    run(40, "R3");

    // R8: alternate saw code restarts the warm-up, then runs as saw
    wave_sel = 2'd3;
    run(40, "R8");

    // R5: pulse, quarter width, then a width change mid-run
    phase_inc = 24'd453438; scale = 32'd8650752; pulse_offset = 24'h400000; wave_sel = 2'd1;
    run(80, "R5");
    pulse_offset = 24'h2A0000;
    run(50, "R5");

    // R6: triangle from the pulse path
    phase_inc = 24'd262144; scale = 32'd2818048; pulse_offset = 24'h800000; wave_sel = 2'd2;
    run(80, "R6");

    // R7: averaged last difference, saw then triangle
    do_reset();
    avg_en = 1'b1; wave_sel = 2'd0; phase_inc = 24'd453438; scale = 32'd17301504;
    run(70, "R7");
    wave_sel = 2'd2; scale = 32'd917504; pulse_offset = 24'h600000;
    run(60, "R7");

    // R10 / R11: stalled output holds, extra strobe is dropped
    avg_en = 1'b0; wave_sel = 2'd0; scale = 32'd17301504;
    run(6, "R9");
    drain();
    out_ready = 1'b0;
    step("R10");
    held = out_data;
    step_en = 1'b1;
    @(negedge clk);
    step_en = 1'b0;
    repeat (3) @(negedge clk);
    check(out_valid && out_data == held, "R10", longint'(out_data), longint'(held));
    out_ready = 1'b1;
    run(30, "R11");

    drain();
    repeat (2) @(negedge clk);
    check(exp_q.size() == 0, "R10", exp_q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule